// File: doc/BRIEF.md
# Video Timing Interrupt Controller

This block turns video timing events into one interrupt line. A periodic timing event comes from exactly one chosen source: the rising edge of the vertical sync input, the moment a line counter reaches a programmed target line, or a 10 ms tick. The tick is made by dividing the clock. The block also watches for timing changes. These are loss of sync, a tracking error above a programmable limit, and a horizontal or vertical period that moves away from its stored reference by more than a programmable limit. Each event sets its own sticky status bit.

The measurement logic sits outside the block. Periods and tracking error arrive as input values. Software reads the status bits, which are always visible on `status_o`, and pulses `rd_stb_i` in the cycle it takes them. That strobe clears every bit except one whose event lands in the same cycle. The interrupt is the OR of the set bits that are enabled, and its output polarity can be chosen. A read forces the interrupt inactive for one cycle. So an event that arrives during a read shows up as a fresh assertion.

Top module: `vtic_top`

## Requirements
- R1: While reset is held and after it is released, before any event arrives, `status_o` is 0 and `irq_o` sits at its inactive level.
- R2: `src_sel_i` picks the periodic source: 0 for the vertical sync rising edge, 1 for line match, 2 for the tick, 3 for none. Status bit 0 is set only by the selected source, and a vertical sync edge does nothing while code 1 or 3 is selected.
- R3: With code 1, status bit 0 is set once when `line_cnt_i` becomes equal to `line_tgt_i`. It is not set again while the count stays at the target.
- R4: With code 2, status bit 0 is set once every `TICK_CYCLES` clocks. With code 3, it is never set.
- R5: A rising edge on `sync_lost_i` sets status bit 1. Holding the input high does not set the bit again.
- R6: Status bit 2 is set when `track_err_i` goes from not above `track_thr_i` to strictly above it. A value equal to the limit does not set it.
- R7: Each period path stores a reference. The first valid sample loads the reference and sets no bit. A later valid sample whose absolute difference from the reference is strictly above `per_thr_i` sets the path's bit (bit 3 for horizontal, bit 4 for vertical) and becomes the new reference.
- R8: Status bits are sticky. The clock edge that samples `rd_stb_i` high clears them, except a bit whose event is sampled on that same edge, which stays set.
- R9: The interrupt is active exactly when some status bit is set and its bit in `irq_en_i` is 1. A disabled event still sets its status bit.
- R10: For the cycle after a read strobe, the interrupt is inactive. On the following edge it becomes active again if enabled bits are still set.
- R11: `irq_pol_i` = 1 makes `irq_o` active high. `irq_pol_i` = 0 makes it active low.
- R12: Status reads never change the stored period references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Periodic source select (0 sync edge, 1 line match, 2 tick, 3 none) |
| vsync_i | input | 1 | Vertical sync level |
| line_cnt_i | input | LW | Current line number |
| line_tgt_i | input | LW | Target line for the line-match source |
| sync_lost_i | input | 1 | Sync loss indication, level |
| track_err_i | input | EW | Measured tracking error |
| track_thr_i | input | EW | Tracking error limit |
| hper_i | input | PW | Measured horizontal period |
| hper_vld_i | input | 1 | `hper_i` holds a new sample |
| vper_i | input | PW | Measured vertical period |
| vper_vld_i | input | 1 | `vper_i` holds a new sample |
| per_thr_i | input | PW | Period change limit |
| irq_en_i | input | 5 | Per-bit interrupt enables |
| irq_pol_i | input | 1 | Interrupt polarity, 1 means active high |
| rd_stb_i | input | 1 | Status read strobe |
| status_o | output | 5 | Sticky status: bit 0 timing, 1 sync loss, 2 tracking, 3 horizontal, 4 vertical |
| irq_o | output | 1 | Interrupt output |

## Verification
Every result is due one clock edge after the stimulus is sampled. Status bits and the interrupt both update on the same edge that sees the input change, and the read gap lasts exactly the one cycle after the strobe edge. The bench changes inputs just after a rising edge and checks outputs just after the next one, so each check lands on that single edge. The tick is checked by the spacing between hits while reads run every cycle, because its phase after reset is not visible at the ports. The line, tracking and period checks sweep whole value ranges against limits worked out in the bench.

// File: rtl/vtic_pkg.sv
package vtic_pkg;
  localparam int unsigned N_EV = 5;
  localparam int unsigned EV_TIME  = 0;
  localparam int unsigned EV_SLOSS = 1;
  localparam int unsigned EV_TRACK = 2;
  localparam int unsigned EV_HCHG  = 3;
  localparam int unsigned EV_VCHG  = 4;

  typedef enum logic [1:0] {
    SRC_VSYNC = 2'd0,
    SRC_LINE  = 2'd1,
    SRC_TICK  = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/vtic_edge.sv
module vtic_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // one pulse per edge; a held level cannot retrigger
  p_edge_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/vtic_tick.sv
module vtic_tick #(
  parameter int unsigned TICK_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/vtic_period_cmp.sv
module vtic_period_cmp
  import vtic_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] per_i,
  input  logic          vld_i,
  input  logic [PW-1:0] thr_i,
  output logic          chg_o
);
  logic [PW-1:0] ref_q;
  logic          have_q;
  logic          beyond;

  assign beyond = abs_diff(32'(per_i), 32'(ref_q)) > 32'(thr_i);
  assign chg_o  = vld_i & have_q & beyond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      have_q <= 1'b0;
    end else if (vld_i) begin
      have_q <= 1'b1;
      if (!have_q || beyond) ref_q <= per_i;
    end
  end

  // references move only on a valid sample, never on a status read
  p_ref_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(ref_q));
  p_ref_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |=> (ref_q == $past(per_i)));
endmodule

// File: rtl/vtic_status.sv
module vtic_status #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  input  logic         rd_stb_i,
  output logic [N-1:0] flags_o,
  output logic         irq_act_o
);
  logic [N-1:0] flags_q, flags_d;
  logic         irq_q, irq_d;

  always_comb begin
    flags_d = set_i | (rd_stb_i ? '0 : flags_q);
    irq_d   = (|(flags_d & en_i)) & ~rd_stb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= irq_d;
    end
  end

  assign flags_o   = flags_q;
  assign irq_act_o = irq_q;

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  p_read_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> !irq_q);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (|(flags_q & $past(en_i))));
endmodule

// File: rtl/vtic_top.sv
module vtic_top
  import vtic_pkg::*;
#(
  parameter int unsigned LW = 12,
  parameter int unsigned EW = 8,
  parameter int unsigned PW = 16,
  parameter int unsigned TICK_CYCLES = 2_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      src_sel_i,
  input  logic            vsync_i,
  input  logic [LW-1:0]   line_cnt_i,
  input  logic [LW-1:0]   line_tgt_i,
  input  logic            sync_lost_i,
  input  logic [EW-1:0]   track_err_i,
  input  logic [EW-1:0]   track_thr_i,
  input  logic [PW-1:0]   hper_i,
  input  logic            hper_vld_i,
  input  logic [PW-1:0]   vper_i,
  input  logic            vper_vld_i,
  input  logic [PW-1:0]   per_thr_i,
  input  logic [N_EV-1:0] irq_en_i,
  input  logic            irq_pol_i,
  input  logic            rd_stb_i,
  output logic [N_EV-1:0] status_o,
  output logic            irq_o
);
  localparam int unsigned N_LVL = 3;

  src_e          src;
  logic [N_LVL-1:0] lvl, rise;
  logic          vs_rise, sl_rise, tr_rise;
  logic          line_hit, tick;
  logic [LW-1:0] line_q;
  logic          time_ev;
  logic [1:0]    per_chg;
  logic [PW-1:0] per_arr [2];
  logic          vld_arr [2];
  logic [N_EV-1:0] set_vec;
  logic          irq_act;

  assign src = src_e'(src_sel_i);

  assign lvl     = {(track_err_i > track_thr_i), sync_lost_i, vsync_i};
  assign vs_rise = rise[0];
  assign sl_rise = rise[1];
  assign tr_rise = rise[2];

  vtic_edge #(.W(N_LVL)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise)
  );

  vtic_tick #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_cnt_i;
  end
  assign line_hit = (line_cnt_i == line_tgt_i) && (line_q != line_tgt_i);

  always_comb begin
    unique case (src)
      SRC_VSYNC: time_ev = vs_rise;
      SRC_LINE:  time_ev = line_hit;
      SRC_TICK:  time_ev = tick;
      default:   time_ev = 1'b0;
    endcase
  end

  assign per_arr[0] = hper_i;
  assign per_arr[1] = vper_i;
  assign vld_arr[0] = hper_vld_i;
  assign vld_arr[1] = vper_vld_i;

  for (genvar g = 0; g < 2; g++) begin : g_per
    vtic_period_cmp #(.PW(PW)) cmp_i (
      .clk(clk), .rst_n(rst_n), .per_i(per_arr[g]), .vld_i(vld_arr[g]),
      .thr_i(per_thr_i), .chg_o(per_chg[g])
    );
  end

  always_comb begin
    set_vec           = '0;
    set_vec[EV_TIME]  = time_ev;
    set_vec[EV_SLOSS] = sl_rise;
    set_vec[EV_TRACK] = tr_rise;
    set_vec[EV_HCHG]  = per_chg[0];
    set_vec[EV_VCHG]  = per_chg[1];
  end

  vtic_status #(.N(N_EV)) stat_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .en_i(irq_en_i),
    .rd_stb_i(rd_stb_i), .flags_o(status_o), .irq_act_o(irq_act)
  );

  assign irq_o = irq_pol_i ? irq_act : ~irq_act;

  // a deselected source never reaches the timing flag
  p_src_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF && !rd_stb_i) |=> (status_o[EV_TIME] == $past(status_o[EV_TIME])));
  p_pol_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == irq_pol_i) == irq_act);
endmodule

// File: tb/vtic_top_tb_top.sv
`timescale 1ns/1ps
module vtic_top_tb_top;
  localparam int LW = 10, EW = 8, PW = 12, TK = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_sel = 2'd3;
  logic vsync = 0, sync_lost = 0, hvld = 0, vvld = 0, pol = 1, rd = 0;
  logic [LW-1:0] line_cnt = '0, line_tgt = 10'd37;
  logic [EW-1:0] terr = '0, tthr = 8'd20;
  logic [PW-1:0] hper = '0, vper = '0, pthr = 12'd5;
  logic [4:0] en = 5'h1f;
  logic [4:0] status;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vtic_top #(.LW(LW), .EW(EW), .PW(PW), .TICK_CYCLES(TK)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel), .vsync_i(vsync),
    .line_cnt_i(line_cnt), .line_tgt_i(line_tgt), .sync_lost_i(sync_lost),
    .track_err_i(terr), .track_thr_i(tthr), .hper_i(hper), .hper_vld_i(hvld),
    .vper_i(vper), .vper_vld_i(vvld), .per_thr_i(pthr), .irq_en_i(en),
    .irq_pol_i(pol), .rd_stb_i(rd), .status_o(status), .irq_o(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int href, vref, hits, last, gap_ok;
    // R1 reset state
    repeat (3) step();
    check("R1 status in reset", status, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1;
    step();
    check("R1 status after reset", status, 0);
    check("R1 irq after reset", irq, 0);

    // R2 vertical sync edge with source 0
    src_sel = 2'd0; vsync = 1; step();
    check("R2 vsync sets bit0", status, 5'b00001);
    check("R9 irq on enabled bit", irq, 1);
    rd = 1; step(); rd = 0;
    check("R8 read clears", status, 0);
    check("R10 irq low after read", irq, 0);
    step();
    check("R2 held vsync no retrigger", status, 0);
    // R2 vsync ignored for other sources
    for (int s = 1; s <= 3; s += 2) begin
      src_sel = 2'(s); vsync = 0; step();
      vsync = 1; step();
      check("R2 vsync ignored when unselected", status[0], 0);
    end
    vsync = 0;

    // R3 line match sweep
    src_sel = 2'd1; line_cnt = '0; rd = 1; step();
    for (int i = 0; i < 64; i++) begin
      line_cnt = 10'(i); step();
      check("R3 line match", status[0], (i == 37));
    end
    line_cnt = 10'd37; step();
    repeat (2) begin
      step();
      check("R3 held line no retrigger", status[0], 0);
    end

    // R4 tick spacing
    src_sel = 2'd2; step();
    hits = 0; last = -1; gap_ok = 1;
    for (int c = 0; c < 5 * TK; c++) begin
      step();
      if (status[0]) begin
        if (last >= 0 && (c - last) != TK) gap_ok = 0;
        last = c; hits++;
      end
    end
    check("R4 tick spacing", gap_ok, 1);
    check("R4 tick count", hits >= 4, 1);
    src_sel = 2'd3; step();
    hits = 0;
    for (int c = 0; c < 3 * TK; c++) begin
      step();
      if (status[0]) hits++;
    end
    check("R4 no tick when off", hits, 0);
    rd = 0; step();

    // R5 sync loss
    sync_lost = 1; step();
    check("R5 sync loss bit1", status, 5'b00010);
    rd = 1; step(); rd = 0; step();
    check("R5 held sync loss no retrigger", status, 0);
    sync_lost = 0;

    // R6 tracking error sweep
    for (int v = 0; v <= 40; v++) begin
      terr = '0; rd = 1; step();
      terr = 8'(v); rd = 0; step();
      check("R6 tracking limit", status[2], (v > 20));
    end
    terr = '0; rd = 1; step(); rd = 0;

    // R7 period references
    hper = 12'd100; vper = 12'd500; hvld = 1; vvld = 1; step();
    hvld = 0; vvld = 0;
    check("R7 first sample no flag", status[4:3], 0);
    href = 100; vref = 500;
    for (int d = -10; d <= 10; d++) begin
      int hv, vv;
      bit he, ve;
      hv = 100 + d; vv = 500 - 2 * d;
      he = ((hv > href) ? hv - href : href - hv) > 5;
      ve = ((vv > vref) ? vv - vref : vref - vv) > 5;
      hper = 12'(hv); vper = 12'(vv); hvld = 1; vvld = 1; step();
      hvld = 0; vvld = 0;
      check("R7 horizontal change", status[3], he);
      check("R7 vertical change", status[4], ve);
      if (he) href = hv;
      if (ve) vref = vv;
      rd = 1; step(); rd = 0;
    end

    // R12 reads leave references unchanged
    rd = 1; repeat (5) step(); rd = 0;
    hper = 12'(href + 5); hvld = 1; step(); hvld = 0;
    check("R12 ref kept across reads, within limit", status[3], 0);
    hper = 12'(href + 6); hvld = 1; step(); hvld = 0;
    check("R12 ref kept across reads, beyond limit", status[3], 1);
    rd = 1; step(); rd = 0;

    // R8 and R10: event during read
    sync_lost = 1; step();
    check("R9 irq active", irq, 1);
    src_sel = 2'd0; vsync = 1; rd = 1; step(); rd = 0;
    check("R8 set during read survives", status, 5'b00001);
    check("R10 irq gap after read", irq, 0);
    step();
    check("R10 irq reasserts", irq, 1);
    sync_lost = 0; vsync = 0;
    rd = 1; step(); rd = 0;

    // R9 masking
    en = 5'b11101; sync_lost = 1; step();
    check("R9 disabled event recorded", status, 5'b00010);
    check("R9 disabled event no irq", irq, 0);
    en = 5'h1f; step();
    check("R9 enabling raises irq", irq, 1);

    // R11 polarity
    pol = 0; #0.5;
    check("R11 active low asserted", irq, 0);
    rd = 1; step(); rd = 0; step();
    check("R11 active low idle", irq, 1);
    pol = 1; #0.5;
    check("R11 active high idle", irq, 0);

    finish_run();
  end
endmodule